// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block keeps a small associative record of loads that were hoisted ahead of stores or branches. When an advanced load completes without a fault, its destination register number and its address are written into a slot. Every store address is compared against the stored addresses, and any slot whose address falls in the same 8-byte granule is dropped. A check operation later presents a register number. If that register still has a slot, the speculatively loaded value is still good and the check reports a hit. If it has no slot, the check asks for the recovery path that reloads the value.

Each slot is a two-state machine. SLOT_EMPTY moves to SLOT_ARMED on a write (alloc). SLOT_ARMED stays armed on a rewrite (refresh). It returns to SLOT_EMPTY on flush, on a store to its granule (snoop kill), or on a faulting advanced load to its register (fault drop). Flush takes priority over a write, and a write takes priority over a kill. A round-robin pointer picks the victim slot when every slot is armed. The check lookup is combinational and sees the table as it stood before the current clock edge. All updates take effect at the next edge.

Top module: `spec_load_tracker`

## Requirements
- R1: After reset every slot is empty, so a check on any register gives chk_recover=1 and chk_hit=0.
- R2: An advanced load with ld_fault=0 arms a slot holding ld_reg and ld_addr. From the next cycle on, a check on that register gives chk_hit=1.
- R3: An advanced load with ld_fault=1 creates no slot. It also empties any slot already held by its register, so a later check on that register recovers.
- R4: A store empties every armed slot whose address bits [ADDR_W-1:3] equal those of st_addr. This covers partial overlaps inside one 8-byte granule. Slots in other granules stay armed.
- R5: When a store and a successful advanced load fall in the same granule in the same cycle, the load's slot ends up armed.
- R6: An advanced load to a register that already holds a slot rewrites that slot and allocates no second one. Reloading a register in a full table evicts nothing.
- R7: A load to a register with no slot takes the lowest-index empty slot. When no slot is empty it evicts the slot at a round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, on each eviction. A check on an evicted register recovers.
- R8: flush empties every slot in one cycle, and it overrides a load in the same cycle.
- R9: chk_hit and chk_recover are combinational in chk_valid and chk_reg. At most one of them is 1, and both are 0 when chk_valid=0. They reflect the table before the current edge, so a load and a check on the same register in one cycle gives recover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the whole table |
| ld_valid | input | 1 | Advanced load completes this cycle |
| ld_fault | input | 1 | The advanced load faulted |
| ld_reg | input | REG_W | Destination register of the load |
| ld_addr | input | ADDR_W | Byte address of the load |
| st_valid | input | 1 | A store is snooped this cycle |
| st_addr | input | ADDR_W | Byte address of the store |
| chk_valid | input | 1 | Check operation this cycle |
| chk_reg | input | REG_W | Register being checked |
| chk_hit | output | 1 | The register's slot is present |
| chk_recover | output | 1 | The slot is missing, so recovery is needed |

## Verification
Some properties are checked by assertions on every cycle. No register ever holds two slots. A flush leaves the table empty on the next cycle. A written slot is armed with the written register number. A snooped store in a slot's granule empties that slot unless the slot is rewritten. Eviction happens only when every slot is armed. Other behaviour shows only in the bench's scenarios, checked through the check port against a reference table: the lowest-free and round-robin victim order, fault drops, the store/load race in one granule, flush beating a load, and the pre-edge view seen by a same-cycle check.

// File: rtl/slt_pkg.sv
package slt_pkg;
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_ARMED = 1'b1
    } slot_state_t;
endpackage

// File: rtl/slt_entry.sv
module slt_entry
    import slt_pkg::*;
#(
    parameter int REG_W = 7,
    parameter int TAG_W = 29
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_reg,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             st_en,
    input  logic [TAG_W-1:0] st_tag,
    input  logic             drop,
    output logic             valid,
    output logic [REG_W-1:0] reg_q,
    output logic [TAG_W-1:0] tag_q
);
    slot_state_t state_q, state_d;
    logic        snoop_hit;

    assign snoop_hit = st_en && (st_tag == tag_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (!flush && wr_en) state_d = SLOT_ARMED;
            end
            SLOT_ARMED: begin
                if (flush)                  state_d = SLOT_EMPTY;
                else if (wr_en)             state_d = SLOT_ARMED;
                else if (snoop_hit || drop) state_d = SLOT_EMPTY;
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
            tag_q <= '0;
        end else if (wr_en && !flush) begin
            reg_q <= wr_reg;
            tag_q <= wr_tag;
        end
    end

    always_comb begin
        valid = (state_q == SLOT_ARMED);
    end

    // R2
    write_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> (valid && reg_q == $past(wr_reg)));

    // R4
    snoop_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && st_en && st_tag == tag_q && !wr_en && !flush) |=> !valid);
endmodule

// File: rtl/slt_alloc.sv
module slt_alloc #(
    parameter int ENTRIES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] own_vec,
    output logic [ENTRIES-1:0] sel,
    output logic               evict
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;
    logic             found;

    always_comb begin
        sel   = '0;
        evict = 1'b0;
        found = 1'b0;
        if (|own_vec) begin
            sel = own_vec;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (!valid_vec[i] && !found) begin
                    sel[i] = 1'b1;
                    found  = 1'b1;
                end
            end
            if (!found) begin
                sel[ptr_q] = 1'b1;
                evict      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              ptr_q <= '0;
        else if (req && evict)   ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    // R7
    evict_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && evict) |-> (&valid_vec));

    // R6
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> ($countones(sel) == 1));
endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker #(
    parameter int ENTRIES   = 8,
    parameter int REG_W     = 7,
    parameter int ADDR_W    = 32,
    parameter int GRAN_BITS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              ld_valid,
    input  logic              ld_fault,
    input  logic [REG_W-1:0]  ld_reg,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    output logic              chk_hit,
    output logic              chk_recover
);
    localparam int TAG_W = ADDR_W - GRAN_BITS;

    logic [ENTRIES-1:0] valid_vec, ld_match, chk_match, sel, wr_vec, drop_vec;
    logic [REG_W-1:0]   reg_arr [ENTRIES];
    logic [TAG_W-1:0]   tag_arr [ENTRIES];
    logic               alloc_req, evict, st_en;
    logic [TAG_W-1:0]   ld_tag, st_tag;

    assign ld_tag    = ld_addr[ADDR_W-1:GRAN_BITS];
    assign st_tag    = st_addr[ADDR_W-1:GRAN_BITS];
    assign alloc_req = ld_valid && !ld_fault && !flush;
    assign st_en     = st_valid && !flush;

    slt_alloc #(.ENTRIES(ENTRIES)) i_alloc (
        .clk(clk), .rst_n(rst_n), .req(alloc_req),
        .valid_vec(valid_vec), .own_vec(ld_match),
        .sel(sel), .evict(evict)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign ld_match[g]  = valid_vec[g] && (reg_arr[g] == ld_reg);
        assign chk_match[g] = valid_vec[g] && (reg_arr[g] == chk_reg);
        assign wr_vec[g]    = alloc_req && sel[g];
        assign drop_vec[g]  = ld_valid && ld_fault && !flush && ld_match[g];

        slt_entry #(.REG_W(REG_W), .TAG_W(TAG_W)) i_entry (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .wr_en(wr_vec[g]), .wr_reg(ld_reg), .wr_tag(ld_tag),
            .st_en(st_en), .st_tag(st_tag), .drop(drop_vec[g]),
            .valid(valid_vec[g]), .reg_q(reg_arr[g]), .tag_q(tag_arr[g])
        );
    end

    always_comb begin
        chk_hit     = chk_valid && (|chk_match);
        chk_recover = chk_valid && !(|chk_match);
    end

    // R6
    unique_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chk_match) <= 1);

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));

    // R9
    chk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_hit && chk_recover) && (chk_valid || (!chk_hit && !chk_recover)));
endmodule

// File: tb/test_spec_load_tracker.sv
module test_spec_load_tracker;
    localparam int N = 8;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 0, ld_valid = 0, ld_fault = 0, st_valid = 0, chk_valid = 0;
    logic [6:0] ld_reg = '0, chk_reg = '0;
    logic [AW-1:0] ld_addr = '0, st_addr = '0;
    logic chk_hit, chk_recover;

    int checks = 0, failures = 0;
    bit done = 0;

    bit          m_v [N];
    logic [6:0]  m_r [N];
    logic [28:0] m_t [N];
    int          m_ptr;

    always #4 clk = ~clk;

    spec_load_tracker i_spec_load_tracker (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .ld_valid(ld_valid), .ld_fault(ld_fault), .ld_reg(ld_reg), .ld_addr(ld_addr),
        .st_valid(st_valid), .st_addr(st_addr),
        .chk_valid(chk_valid), .chk_reg(chk_reg),
        .chk_hit(chk_hit), .chk_recover(chk_recover)
    );

    function automatic bit model_has(logic [6:0] r);
        for (int i = 0; i < N; i++) if (m_v[i] && m_r[i] == r) return 1;
        return 0;
    endfunction

    task automatic model_update();
        bit nv [N];
        int own, tgt;
        if (flush) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
            return;
        end
        for (int i = 0; i < N; i++)
            nv[i] = m_v[i] && !(st_valid && m_t[i] == st_addr[AW-1:3]);
        own = -1;
        for (int i = 0; i < N; i++) if (m_v[i] && m_r[i] == ld_reg) own = i;
        if (ld_valid && ld_fault) begin
            if (own >= 0) nv[own] = 0;
        end else if (ld_valid) begin
            tgt = own;
            if (tgt < 0)
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) tgt = i;
            if (tgt < 0) begin
                tgt = m_ptr;
                m_ptr = (m_ptr + 1) % N;
            end
            nv[tgt] = 1;
            m_r[tgt] = ld_reg;
            m_t[tgt] = ld_addr[AW-1:3];
        end
        for (int i = 0; i < N; i++) m_v[i] = nv[i];
    endtask

    task automatic cyc(bit lv, bit lf, int lr, int la, bit sv, int sa,
                       bit cv, int cr, bit fl, string req);
        bit eh, er;
        ld_valid = lv; ld_fault = lf; ld_reg = 7'(lr); ld_addr = AW'(la);
        st_valid = sv; st_addr = AW'(sa);
        chk_valid = cv; chk_reg = 7'(cr); flush = fl;
        #1;
        eh = cv && model_has(7'(cr));
        er = cv && !eh;
        checks++;
        if (chk_hit !== eh || chk_recover !== er) begin
            failures++;
            $display("FAIL %s: reg %0d hit/recover=%b%b expected %b%b",
                     req, cr, chk_hit, chk_recover, eh, er);
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_r[i] = '0; m_t[i] = '0; end
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        cyc(0,0,0,0, 0,0, 1,5, 0, "R1 reset empty");
        cyc(0,0,0,0, 0,0, 1,0, 0, "R1 reset empty");
        cyc(1,0,5,'h100, 0,0, 0,0, 0, "R2 load");
        cyc(0,0,0,0, 0,0, 1,5, 0, "R2 hit after load");
        cyc(1,0,6,'h180, 0,0, 1,6, 0, "R9 same-cycle check sees old state");
        cyc(0,0,0,0, 0,0, 1,6, 0, "R9 hit next cycle");
        cyc(0,0,0,0, 1,'h104, 1,5, 0, "R4 check before store takes effect");
        cyc(0,0,0,0, 0,0, 1,5, 0, "R4 partial overlap kills");
        cyc(1,0,7,'h200, 0,0, 0,0, 0, "R2 load");
        cyc(0,0,0,0, 1,'h208, 1,7, 0, "R4 other granule");
        cyc(0,0,0,0, 0,0, 1,7, 0, "R4 other granule keeps entry");
        cyc(1,1,7,'h200, 0,0, 0,0, 0, "R3 fault load");
        cyc(0,0,0,0, 0,0, 1,7, 0, "R3 fault drops existing entry");
        cyc(1,1,9,'h280, 0,0, 0,0, 0, "R3 fault load");
        cyc(0,0,0,0, 0,0, 1,9, 0, "R3 fault creates nothing");
        cyc(1,0,4,'h300, 1,'h303, 0,0, 0, "R5 race");
        cyc(0,0,0,0, 0,0, 1,4, 0, "R5 load wins race");
        cyc(1,0,2,'h400, 0,0, 0,0, 1, "R8 flush with load");
        cyc(0,0,0,0, 0,0, 1,2, 0, "R8 flush beats load");
        cyc(0,0,0,0, 0,0, 1,4, 0, "R8 flush clears");
        for (int i = 0; i < N; i++) cyc(1,0,i,i*16, 0,0, 0,0, 0, "R7 fill");
        cyc(1,0,3,'h900, 0,0, 0,0, 0, "R6 reload");
        for (int i = 0; i < N; i++) cyc(0,0,0,0, 0,0, 1,i, 0, "R6 no eviction on reload");
        cyc(1,0,8,'h1000, 0,0, 0,0, 0, "R7 evict");
        cyc(0,0,0,0, 0,0, 1,0, 0, "R7 slot 0 evicted");
        cyc(0,0,0,0, 0,0, 1,8, 0, "R7 new entry");
        cyc(1,0,9,'h1100, 0,0, 0,0, 0, "R7 evict");
        cyc(0,0,0,0, 0,0, 1,1, 0, "R7 slot 1 evicted");
        cyc(0,0,0,0, 0,0, 1,2, 0, "R7 slot 2 kept");
        cyc(0,0,0,0, 0,0, 0,2, 0, "R9 idle outputs low");

        for (int k = 0; k < 3000; k++) begin
            cyc($urandom_range(0,1), ($urandom_range(0,5) == 0),
                $urandom_range(0,11), $urandom_range(0,127),
                $urandom_range(0,2) == 0, $urandom_range(0,127),
                $urandom_range(0,3) != 0, $urandom_range(0,11),
                ($urandom_range(0,99) == 0), "R2 R3 R4 R5 R6 R7 R8 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule